// File: doc/BRIEF.md
# Single-Line Reset and Configuration Master

This block is the line-side engine of a master for a one-wire, open-drain serial bus. A host presents commands through a small synchronous interface: a one-cycle strobe with a command code and a parameter byte. The block answers in the same cycle with an accept flag. It also exposes a status byte and a configuration byte that the host can read at any time.

Two commands are handled. The first loads four configuration bits: overdrive speed, strong pullup, presence masking and active pullup. It guards the load with an integrity rule: the upper nibble of the parameter must be the bitwise inverse of the lower nibble. The second runs a bus reset. The master holds the line low for a reset low-time and then releases it for a recovery time. While the line is released it samples the line twice. An early sample reveals a shorted line. A later sample catches a slave's presence pulse. Both results land in the status byte. The overdrive bit picks between two parameterised timing sets.

Top module: `owm_top`

## Requirements
- R1: After reset, `status_o` reads 8'h10 (only the power-up flag at bit 4 set), `config_o` reads 8'h00, `line_drive_o` is 0 and `cmd_ack` is 0.
- R2: A strobe with code 8'hA5 that is accepted loads the configuration only when `cmd_param[7:4] == ~cmd_param[3:0]`. The bits land as active pullup = bit 0, presence masking = bit 1, strong pullup = bit 2 and overdrive = bit 3. A parameter failing the rule leaves the configuration unchanged.
- R3: `config_o[7:4]` always reads 0, and `config_o[3:0]` holds the stored bits.
- R4: A configuration load that passes the rule clears the power-up flag (`status_o[4]`).
- R5: `cmd_ack` is 1 exactly when `cmd_valid` is 1, the busy bit (`status_o[0]`) is 0 and the code is 8'hA5 or 8'h3C. A strobe that is not acknowledged changes nothing.
- R6: An accepted code 8'h3C raises busy from the next cycle. Busy stays high for RSTL+RSTH cycles. `line_drive_o` is high for the first RSTL of those cycles.
- R7: The line input passes through two flops. Let k count cycles from the first busy cycle, starting at 0. The synchronised line is sampled at k = RSTL+MSP, and the presence bit `status_o[1]` becomes 1 if that sample is low and 0 otherwise.
- R8: In the same way, the short bit `status_o[2]` is set from a low sample at k = RSTL+SI and cleared by a high one.
- R9: The standard timing set (RSTL, RSTH, MSP, SI) applies while the overdrive bit is 0. The overdrive set applies while it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| cmd_param | input | 8 | Parameter byte for configuration load |
| cmd_ack | output | 1 | Command accepted (combinational) |
| status_o | output | 8 | Status byte: busy, presence, short, power-up flag |
| config_o | output | 8 | Configuration readback, upper nibble zero |
| line_drive_o | output | 1 | Pull the bus line low when 1 |
| line_i | input | 1 | Bus line level |

## Verification
The accept flag is combinational, so the bench reads it one time-step after it raises the strobe at a falling edge. Configuration and flag changes are due at the next rising edge and are read at the falling edge after it. For a reset command, the bench walks falling edges from the first busy cycle and counts busy and drive cycles against RSTL+RSTH and RSTL. Its slave model times the presence pulse and a short from the release of the drive, so that the two-flop delay puts the SI sample before the pulse and the MSP sample inside it. The presence and short bits are checked once busy has fallen.

// File: rtl/ow_pkg.sv
package ow_pkg;

    localparam logic [7:0] CMD_CFG = 8'hA5;
    localparam logic [7:0] CMD_RST = 8'h3C;

    typedef struct packed {
        logic spd;   // overdrive speed
        logic spu;   // strong pullup
        logic ppm;   // presence masking
        logic apu;   // active pullup
    } cfg_t;

    function automatic logic nib_ok(input logic [7:0] d);
        return d[7:4] == ~d[3:0];
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/ow_cfg_reg.sv
module ow_cfg_reg
    import ow_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] data,
    output cfg_t       cfg,
    output logic       wr_ok
);
    assign wr_ok = wr && nib_ok(data);

    always_ff @(posedge clk) begin
        if (rst)        cfg <= '0;
        else if (wr_ok) cfg <= cfg_t'(data[3:0]);
    end
endmodule

// File: rtl/ow_rst_seq.sv
module ow_rst_seq
    import ow_pkg::*;
#(
    parameter int T_RSTL_STD = 40,
    parameter int T_RSTH_STD = 40,
    parameter int T_MSP_STD  = 14,
    parameter int T_SI_STD   = 4,
    parameter int T_RSTL_OD  = 12,
    parameter int T_RSTH_OD  = 16,
    parameter int T_MSP_OD   = 6,
    parameter int T_SI_OD    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic od,
    input  logic line_s,
    output logic busy,
    output logic drive,
    output logic ppd,
    output logic sd
);
    localparam int TOT_S = T_RSTL_STD + T_RSTH_STD;
    localparam int TOT_O = T_RSTL_OD + T_RSTH_OD;
    localparam int CW    = $clog2(imax(TOT_S, TOT_O) + 1);

    localparam logic [CW-1:0] LAST_S = CW'(TOT_S - 1);
    localparam logic [CW-1:0] LAST_O = CW'(TOT_O - 1);
    localparam logic [CW-1:0] LOW_S  = CW'(T_RSTL_STD);
    localparam logic [CW-1:0] LOW_O  = CW'(T_RSTL_OD);
    localparam logic [CW-1:0] MSP_S  = CW'(T_RSTL_STD + T_MSP_STD);
    localparam logic [CW-1:0] MSP_O  = CW'(T_RSTL_OD + T_MSP_OD);
    localparam logic [CW-1:0] SI_S   = CW'(T_RSTL_STD + T_SI_STD);
    localparam logic [CW-1:0] SI_O   = CW'(T_RSTL_OD + T_SI_OD);

    logic [CW-1:0] cnt;
    logic          od_q;
    logic [CW-1:0] last_c, low_c, msp_c, si_c;

    always_comb begin
        last_c = od_q ? LAST_O : LAST_S;
        low_c  = od_q ? LOW_O  : LOW_S;
        msp_c  = od_q ? MSP_O  : MSP_S;
        si_c   = od_q ? SI_O   : SI_S;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            od_q <= 1'b0;
            ppd  <= 1'b0;
            sd   <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
            od_q <= od;
        end else if (busy) begin
            if (cnt == last_c) busy <= 1'b0;
            else               cnt  <= cnt + 1'b1;
            if (cnt == si_c)  sd  <= ~line_s;
            if (cnt == msp_c) ppd <= ~line_s;
        end
    end

    assign drive = busy && (cnt < low_c);
endmodule

// File: rtl/owm_top.sv
module owm_top
    import ow_pkg::*;
#(
    parameter int T_RSTL_STD = 40,
    parameter int T_RSTH_STD = 40,
    parameter int T_MSP_STD  = 14,
    parameter int T_SI_STD   = 4,
    parameter int T_RSTL_OD  = 12,
    parameter int T_RSTH_OD  = 16,
    parameter int T_MSP_OD   = 6,
    parameter int T_SI_OD    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    input  logic [7:0] cmd_param,
    output logic       cmd_ack,
    output logic [7:0] status_o,
    output logic [7:0] config_o,
    output logic       line_drive_o,
    input  logic       line_i
);
    logic busy, ppd, sd, line_s, cfg_ok, pwr_flag;
    cfg_t cfg;

    assign cmd_ack = cmd_valid && !busy &&
                     ((cmd_code == CMD_CFG) || (cmd_code == CMD_RST));

    ow_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(line_i), .q(line_s)
    );

    ow_cfg_reg u_cfg (
        .clk(clk), .rst(rst),
        .wr(cmd_ack && (cmd_code == CMD_CFG)),
        .data(cmd_param), .cfg(cfg), .wr_ok(cfg_ok)
    );

    ow_rst_seq #(
        .T_RSTL_STD(T_RSTL_STD), .T_RSTH_STD(T_RSTH_STD),
        .T_MSP_STD(T_MSP_STD),   .T_SI_STD(T_SI_STD),
        .T_RSTL_OD(T_RSTL_OD),   .T_RSTH_OD(T_RSTH_OD),
        .T_MSP_OD(T_MSP_OD),     .T_SI_OD(T_SI_OD)
    ) u_seq (
        .clk(clk), .rst(rst),
        .start(cmd_ack && (cmd_code == CMD_RST)),
        .od(cfg.spd), .line_s(line_s),
        .busy(busy), .drive(line_drive_o), .ppd(ppd), .sd(sd)
    );

    always_ff @(posedge clk) begin
        if (rst)         pwr_flag <= 1'b1;
        else if (cfg_ok) pwr_flag <= 1'b0;
    end

    assign status_o = {3'b000, pwr_flag, 1'b0, sd, ppd, busy};
    assign config_o = {4'h0, cfg};
endmodule

// File: rtl/ow_chk.sv
module ow_chk
    import ow_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [7:0] cmd_code,
    input logic [7:0] cmd_param,
    input logic       cmd_ack,
    input logic [7:0] status_o,
    input logic [7:0] config_o,
    input logic       line_drive_o
);
    always_comb begin
        if (!rst) AST_CFG_UPPER_ZERO: assert (config_o[7:4] == 4'h0); // R3
    end

    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (rst)
        status_o[0] |-> !cmd_ack); // R5

    AST_DRIVE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        line_drive_o |-> status_o[0]); // R6

    AST_RST_CMD_START: assert property (@(posedge clk) disable iff (rst)
        (cmd_ack && cmd_code == CMD_RST) |=> (status_o[0] && line_drive_o)); // R6

    AST_CFG_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        status_o[0] |=> $stable(config_o)); // R2

    AST_PWR_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cmd_ack && cmd_code == CMD_CFG && cmd_param[7:4] == ~cmd_param[3:0])
        |=> !status_o[4]); // R4
endmodule

bind owm_top ow_chk u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_param(cmd_param), .cmd_ack(cmd_ack), .status_o(status_o),
    .config_o(config_o), .line_drive_o(line_drive_o)
);

// File: tb/test_owm_top.sv
module test_owm_top;
    localparam int CLK_PERIOD = 10;
    localparam int RL_S = 40, RH_S = 40, MSP_S = 14, SI_S = 4;
    localparam int RL_O = 12, RH_O = 16, MSP_O = 6,  SI_O = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic [7:0] cmd_param = 8'h00;
    logic       cmd_ack, line_drive_o, line_i;
    logic [7:0] status_o, config_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // slave model
    bit       pres_en = 1'b0;
    bit       short_en = 1'b0;
    int       pres_dly = 6;
    int       pres_wid = 20;
    int       since_rel = 255;
    logic     slave_low;

    always @(posedge clk) begin
        if (line_drive_o)         since_rel <= 0;
        else if (since_rel < 255) since_rel <= since_rel + 1;
    end

    assign slave_low = pres_en && (since_rel >= pres_dly) &&
                       (since_rel < pres_dly + pres_wid);
    assign line_i = !(line_drive_o || slave_low || short_en);

    always #(CLK_PERIOD/2) clk = ~clk;

    owm_top #(
        .T_RSTL_STD(RL_S), .T_RSTH_STD(RH_S), .T_MSP_STD(MSP_S), .T_SI_STD(SI_S),
        .T_RSTL_OD(RL_O),  .T_RSTH_OD(RH_O),  .T_MSP_OD(MSP_O),  .T_SI_OD(SI_O)
    ) i_owm_top (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_param(cmd_param), .cmd_ack(cmd_ack), .status_o(status_o),
        .config_o(config_o), .line_drive_o(line_drive_o), .line_i(line_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] code, input logic [7:0] param,
                         output logic ack);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code;
        cmd_param = param;
        #1 ack = cmd_ack;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        chk(status_o == 8'h10, "R1", "status", status_o, 8'h10);
        chk(config_o == 8'h00, "R1", "config", config_o, 8'h00);
        chk(line_drive_o == 1'b0, "R1", "drive", line_drive_o, 0);
        chk(cmd_ack == 1'b0, "R1", "ack", cmd_ack, 0);
    endtask

    task automatic t_cfg(input logic [7:0] p, input logic [7:0] exp_cfg,
                         input bit exp_flag);
        logic a;
        issue(8'hA5, p, a);
        chk(a == 1'b1, "R5", "cfg ack", a, 1);
        chk(config_o == exp_cfg, "R2", "config", config_o, exp_cfg);
        chk(config_o[7:4] == 4'h0, "R3", "upper nibble", config_o[7:4], 0);
        chk(status_o[4] == exp_flag, "R4", "power-up flag", status_o[4], exp_flag);
    endtask

    task automatic t_unknown();
        logic a;
        logic [7:0] c0, s0;
        c0 = config_o; s0 = status_o;
        issue(8'h77, 8'hE1, a);
        chk(a == 1'b0, "R5", "unknown ack", a, 0);
        chk(config_o == c0, "R5", "unknown config", config_o, c0);
        chk(status_o == s0, "R5", "unknown status", status_o, s0);
    endtask

    task automatic t_bus_reset(input bit pres, input bit shrt, input bit od,
                               input bit try_cfg);
        logic a, a2;
        int nb, nd, exp_b, exp_d;
        logic [7:0] c0;
        pres_en  = pres;
        short_en = shrt;
        pres_dly = od ? 2 : 6;
        pres_wid = od ? 8 : 20;
        exp_d = od ? RL_O : RL_S;
        exp_b = od ? RL_O + RH_O : RL_S + RH_S;
        c0 = config_o;
        issue(8'h3C, 8'h00, a);
        chk(a == 1'b1, "R5", "reset ack", a, 1);
        nb = 0; nd = 0;
        while (status_o[0] && nb < 1000) begin
            nb++;
            if (line_drive_o) nd++;
            if (try_cfg && nb == 3) begin
                cmd_valid = 1'b1; cmd_code = 8'hA5; cmd_param = 8'h0F;
                #1 a2 = cmd_ack;
                chk(a2 == 1'b0, "R5", "cfg ack while busy", a2, 0);
            end
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        chk(nb == exp_b, od ? "R9" : "R6", "busy cycles", nb, exp_b);
        chk(nd == exp_d, od ? "R9" : "R6", "drive cycles", nd, exp_d);
        chk(status_o[1] == (pres || shrt), "R7", "presence bit",
            status_o[1], (pres || shrt));
        chk(status_o[2] == shrt, "R8", "short bit", status_o[2], shrt);
        if (try_cfg) chk(config_o == c0, "R5", "config after busy write", config_o, c0);
        pres_en = 1'b0;
        short_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_cfg(8'h33, 8'h00, 1'b1);            // R2 bad nibble keeps config and flag
        t_cfg(8'hE1, 8'h01, 1'b0);            // R2 R4 apu set
        t_cfg(8'h96, 8'h06, 1'b0);            // R2 ppm+spu
        t_unknown();
        t_bus_reset(1'b0, 1'b0, 1'b0, 1'b1);  // R6 no slave, busy reject
        t_bus_reset(1'b1, 1'b0, 1'b0, 1'b0);  // R7 presence
        t_bus_reset(1'b0, 1'b1, 1'b0, 1'b0);  // R8 short
        t_bus_reset(1'b0, 1'b0, 1'b0, 1'b0);  // R7 R8 results cleared
        t_cfg(8'h78, 8'h08, 1'b0);            // R9 overdrive on
        t_bus_reset(1'b1, 1'b0, 1'b1, 1'b0);  // R9 overdrive presence
        t_bus_reset(1'b0, 1'b1, 1'b1, 1'b0);  // R9 overdrive short
        t_cfg(8'hF0, 8'h00, 1'b0);            // R3 back to zero
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule